// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block sits beside the command bus of a four-bank synchronous DRAM and judges every command it sees. It keeps one state per bank (idle, row active, reading, writing) and compares each command with the state of the bank that the bank-select bits address. For mode set and refresh, it compares against all banks together. Legal commands move the addressed bank to its next state. Illegal commands raise a one-cycle error pulse and change nothing.

Per-bank cycle counters enforce three minimum spacings, each given as a parameter count: activate to column access, activate to precharge, and activate to activate across banks. The block also flags when auto precharge is requested, and whether a refresh is an auto refresh or a self-refresh entry. It flags when a no-operation places the device in power down. The data path, refresh scheduling and mode register contents are out of scope. All outputs are registered, so the result of a command sampled at a clock edge appears just after that edge.

Top module: `sdram_cmd_legality_chk`

## Requirements
- R1: After reset all banks are idle and every output pulse is low. `bank_st_o` carries bank n in bits [2n+1:2n], with idle=0, row active=1, reading=2 and writing=3. A command changes only the bank it addresses.
- R2: Command decode with cs_n low, from {ras_n,cas_n,we_n}:
  - 000 is mode set
  - 001 is refresh
  - 010 is precharge
  - 011 is activate
  - 100 is write
  - 101 is read
  - 110 and 111 are no-operation

  With cs_n high the command is deselect. Mode set and refresh are legal only while all banks are idle, and they leave the states unchanged.
- R3: A legal refresh with cke high pulses `aref_o`. A legal refresh with cke low pulses `selfref_o`.
- R4: No-operation and deselect are always legal and change no state. With cke low and the addressed bank idle, they pulse `pdown_o`.
- R5: Read or write to an idle bank is illegal. Activate to a bank that is not idle is illegal.
- R6: A legal activate moves an idle bank to row active.
- R7: Read or write to a row-active bank is legal only once at least TRCD cycles have passed since that bank's activate.
- R8: Precharge to a row-active bank is legal only once at least TRAS cycles have passed since its activate, and it returns the bank to idle. Precharge to an idle bank is legal and changes nothing.
- R9: In the reading or writing state, read and write are legal at once and move the bank to reading or writing. Precharge is also legal at once and returns the bank to idle.
- R10: A legal read or write with address bit 10 set pulses `ap_o`.
- R11: An illegal command pulses `err_o` for one cycle and leaves every bank state unchanged.
- R12: An activate fewer than TRRD cycles after the last legal activate to any bank is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable level |
| ba | input | BA_W (2) | Bank select |
| addr | input | ADDR_W (13) | Address bus; bit 10 requests auto precharge |
| err_o | output | 1 | Illegal command pulse |
| ap_o | output | 1 | Auto precharge requested |
| aref_o | output | 1 | Auto refresh started |
| selfref_o | output | 1 | Self refresh entered |
| pdown_o | output | 1 | Power down entered |
| bank_st_o | output | 2*NB (8) | Packed bank states |

## Verification
On every cycle, the assertions check the following:
- illegal column accesses to idle banks and activates to busy banks raise the error
- mode set and refresh raise it while any bank is busy
- spacing violations on activate, column access and precharge raise it
- an error freezes all bank states
- at most one bank changes state per cycle
- the auto-precharge flag follows only a read or write

Only the bench scenarios can show that the legal paths give the right next state and the right refresh or power-down flag. Directed sequences cover the exact spacing boundaries. Seeded random traffic compared against a bench-side model covers burst interruption and mixed traffic across banks.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_ACT  = 2'd1,
    BK_RD   = 2'd2,
    BK_WR   = 2'd3
  } bank_st_e;

  typedef enum logic [2:0] {
    C_DESEL, C_NOP, C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  c = C_MRS;
        3'b001:  c = C_REF;
        3'b010:  c = C_PRE;
        3'b011:  c = C_ACT;
        3'b100:  c = C_WR;
        3'b101:  c = C_RD;
        default: c = C_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic judge(input cmd_e c, input bank_st_e s,
                                 input logic all_idle, input logic rcd_ok,
                                 input logic ras_ok, input logic rrd_ok);
    logic ok;
    case (c)
      C_MRS, C_REF: ok = all_idle;
      C_PRE:        ok = (s == BK_ACT) ? ras_ok : 1'b1;
      C_ACT:        ok = (s == BK_IDLE) && rrd_ok;
      C_RD, C_WR:   ok = (s == BK_IDLE) ? 1'b0 : ((s == BK_ACT) ? rcd_ok : 1'b1);
      default:      ok = 1'b1;
    endcase
    return ok;
  endfunction

  function automatic bank_st_e next_state(input cmd_e c, input bank_st_e s);
    bank_st_e n;
    case (c)
      C_ACT:   n = BK_ACT;
      C_RD:    n = BK_RD;
      C_WR:    n = BK_WR;
      C_PRE:   n = BK_IDLE;
      default: n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_chk_pkg::*;
#(
  parameter int TMAX = 6,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  bank_st_e      nxt,
  output bank_st_e      st,
  output logic [CW-1:0] since
);
  localparam logic [CW-1:0] SAT = CW'(TMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= BK_IDLE;
      since <= '0;
    end else begin
      if (upd) st <= nxt;
      if (upd && nxt == BK_ACT && st == BK_IDLE) since <= CW'(1);
      else if (since < SAT) since <= since + CW'(1);
    end
  end
endmodule

// File: rtl/sdram_rrd_timer.sv
module sdram_rrd_timer #(
  parameter int TMAX = 6,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_fire,
  output logic [CW-1:0] since
);
  localparam logic [CW-1:0] SAT = CW'(TMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)             since <= SAT;
    else if (act_fire)      since <= CW'(1);
    else if (since < SAT)   since <= since + CW'(1);
  end
endmodule

// File: rtl/sdram_cmd_legality_chk.sv
module sdram_cmd_legality_chk
  import sdram_chk_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int TRCD   = 3,
  parameter int TRAS   = 6,
  parameter int TRRD   = 2,
  parameter int BA_W   = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              err_o,
  output logic              ap_o,
  output logic              aref_o,
  output logic              selfref_o,
  output logic              pdown_o,
  output logic [2*NB-1:0]   bank_st_o
);
  localparam int TMAX0 = (TRCD > TRAS) ? TRCD : TRAS;
  localparam int TMAX  = (TMAX0 > TRRD) ? TMAX0 : TRRD;
  localparam int CW    = $clog2(TMAX + 1);

  cmd_e            cmd;
  bank_st_e        st_q    [NB];
  logic [CW-1:0]   since_q [NB];
  logic [CW-1:0]   rrd_since;
  bank_st_e        sel_st;
  bank_st_e        sel_nxt;
  logic            all_idle;
  logic            rcd_ok, ras_ok, rrd_ok;
  logic            cmd_legal;
  logic            act_fire;
  logic [NB-1:0]   upd_vec;

  sdram_cmd_decoder u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign sel_st = st_q[ba];
  assign rcd_ok = since_q[ba] >= CW'(TRCD);
  assign ras_ok = since_q[ba] >= CW'(TRAS);
  assign rrd_ok = rrd_since   >= CW'(TRRD);

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NB; i++)
      if (st_q[i] != BK_IDLE) all_idle = 1'b0;
  end

  assign cmd_legal = judge(cmd, sel_st, all_idle, rcd_ok, ras_ok, rrd_ok);
  assign sel_nxt   = next_state(cmd, sel_st);
  assign act_fire  = cmd_legal && (cmd == C_ACT);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign upd_vec[g] = cmd_legal && (ba == BA_W'(g));
    sdram_bank_tracker #(.TMAX(TMAX), .CW(CW)) u_trk (
      .clk(clk), .rst_n(rst_n), .upd(upd_vec[g]), .nxt(sel_nxt),
      .st(st_q[g]), .since(since_q[g])
    );
    assign bank_st_o[2*g +: 2] = st_q[g];
  end

  sdram_rrd_timer #(.TMAX(TMAX), .CW(CW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .act_fire(act_fire), .since(rrd_since)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_o     <= 1'b0;
      ap_o      <= 1'b0;
      aref_o    <= 1'b0;
      selfref_o <= 1'b0;
      pdown_o   <= 1'b0;
    end else begin
      err_o     <= !cmd_legal;
      ap_o      <= cmd_legal && (cmd == C_RD || cmd == C_WR) && addr[AP_BIT];
      aref_o    <= cmd_legal && (cmd == C_REF) && cke;
      selfref_o <= cmd_legal && (cmd == C_REF) && !cke;
      pdown_o   <= (cmd == C_NOP || cmd == C_DESEL) && !cke && (sel_st == BK_IDLE);
    end
  end

endmodule

// File: rtl/sdram_chk_sva.sv
module sdram_chk_sva
  import sdram_chk_pkg::*;
#(
  parameter int NB = 4
) (
  input logic            clk,
  input logic            rst_n,
  input cmd_e            cmd,
  input bank_st_e        sel_st,
  input logic            all_idle,
  input logic            rcd_ok,
  input logic            ras_ok,
  input logic            rrd_ok,
  input logic            err_o,
  input logic            ap_o,
  input logic [2*NB-1:0] bank_st_o
);
  logic [2*NB-1:0] prev_q;
  logic [NB-1:0]   chg;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= bank_st_o;
  end

  always_comb
    for (int i = 0; i < NB; i++)
      chg[i] = bank_st_o[2*i +: 2] != prev_q[2*i +: 2];

  AST_RDWR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_RD || cmd == C_WR) && sel_st == BK_IDLE) |=> err_o); // R5
  AST_ACT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && sel_st != BK_IDLE) |=> err_o); // R5
  AST_GLOBAL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_MRS || cmd == C_REF) && !all_idle) |=> err_o); // R2
  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_RD || cmd == C_WR) && sel_st == BK_ACT && !rcd_ok) |=> err_o); // R7
  AST_RAS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE && sel_st == BK_ACT && !ras_ok) |=> err_o); // R8
  AST_RRD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && !rrd_ok) |=> err_o); // R12
  AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (bank_st_o == prev_q)); // R11
  AST_ONE_BANK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1); // R1
  AST_AP_AFTER_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
    ap_o |-> (!err_o && ($past(cmd) == C_RD || $past(cmd) == C_WR))); // R10

endmodule

bind sdram_cmd_legality_chk sdram_chk_sva #(.NB(NB)) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel_st(sel_st), .all_idle(all_idle),
  .rcd_ok(rcd_ok), .ras_ok(ras_ok), .rrd_ok(rrd_ok), .err_o(err_o),
  .ap_o(ap_o), .bank_st_o(bank_st_o)
);

// File: tb/sdram_cmd_legality_chk_tb_top.sv
module sdram_cmd_legality_chk_tb_top;
  localparam int NB = 4, ADDR_W = 13, TRCD = 3, TRAS = 6, TRRD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic err_o, ap_o, aref_o, selfref_o, pdown_o;
  logic [2*NB-1:0] bank_st_o;

  int errors = 0, checks = 0;
  int mst [NB];
  int msince [NB];
  int mrrd = 1000;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_cmd_legality_chk #(.NB(NB), .ADDR_W(ADDR_W), .TRCD(TRCD), .TRAS(TRAS),
                           .TRRD(TRRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .err_o(err_o), .ap_o(ap_o),
    .aref_o(aref_o), .selfref_o(selfref_o), .pdown_o(pdown_o),
    .bank_st_o(bank_st_o)
  );

  // command codes: 0 desel,1 nop,2 mode,3 refresh,4 pre,5 act,6 write,7 read
  function automatic int kind(input logic cs, input logic [2:0] rcw);
    if (cs) return 0;
    case (rcw)
      3'b000: return 2;
      3'b001: return 3;
      3'b010: return 4;
      3'b011: return 5;
      3'b100: return 6;
      3'b101: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic bit ok_model(input int k, input int b);
    bit idle_all = 1;
    for (int i = 0; i < NB; i++) if (mst[i] != 0) idle_all = 0;
    case (k)
      2, 3: return idle_all;
      4: return (mst[b] == 1) ? (msince[b] >= TRAS) : 1;
      5: return (mst[b] == 0) && (mrrd >= TRRD);
      6, 7: return (mst[b] == 0) ? 0 : ((mst[b] == 1) ? (msince[b] >= TRCD) : 1);
      default: return 1;
    endcase
  endfunction

  function automatic logic [2*NB-1:0] pack_model();
    logic [2*NB-1:0] v;
    for (int i = 0; i < NB; i++) v[2*i +: 2] = 2'(mst[i]);
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
  task automatic step(input string tag, input logic cs, input logic [2:0] rcw,
                      input logic ck, input int b, input logic a10);
    int k;
    bit ok;
    logic e_ap, e_ar, e_sr, e_pd;
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; cke = ck; ba = 2'(b);
    addr = ADDR_W'($urandom); addr[10] = a10;
    k  = kind(cs, rcw);
    ok = ok_model(k, b);
    e_ap = ok && (k == 6 || k == 7) && a10;
    e_ar = ok && k == 3 && ck;
    e_sr = ok && k == 3 && !ck;
    e_pd = (k <= 1) && !ck && mst[b] == 0;
    for (int i = 0; i < NB; i++) msince[i]++;
    mrrd++;
    if (ok) begin
      case (k)
        4: mst[b] = 0;
        5: begin mst[b] = 1; msince[b] = 1; mrrd = 1; end
        6: mst[b] = 3;
        7: mst[b] = 2;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "err", {7'b0, err_o}, {7'b0, !ok});
    chk("R10", "ap", {7'b0, ap_o}, {7'b0, e_ap});
    chk("R3", "aref", {7'b0, aref_o}, {7'b0, e_ar});
    chk("R3", "selfref", {7'b0, selfref_o}, {7'b0, e_sr});
    chk("R4", "pdown", {7'b0, pdown_o}, {7'b0, e_pd});
    chk("R1", "bank_st", 8'(bank_st_o), 8'(pack_model()));
  endtask

  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, PRE = 3'b010, ACT = 3'b011,
                         WR = 3'b100, RD = 3'b101, NOP = 3'b111;

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D2A_0C17));
    for (int i = 0; i < NB; i++) begin mst[i] = 0; msince[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "reset err", {7'b0, err_o}, 8'd0);
    chk("R1", "reset states", 8'(bank_st_o), 8'd0);
    chk("R1", "reset pdown", {7'b0, pdown_o}, 8'd0);
    // R2/R3/R4 with all banks idle
    step("R2", 0, MRS, 1, 0, 0);
    step("R3", 0, REF, 1, 1, 0);
    step("R3", 0, REF, 0, 2, 0);
    step("R4", 0, NOP, 0, 3, 0);
    step("R4", 1, NOP, 0, 0, 0);
    // R5 read to idle
    step("R5", 0, RD, 1, 0, 0);
    // R6 activate, R12 activate too soon on another bank
    step("R6", 0, ACT, 1, 0, 0);
    step("R12", 0, ACT, 1, 1, 0);
    step("R12", 0, ACT, 1, 1, 0);
    // R7 read on bank 1 one cycle after its activate
    step("R7", 0, RD, 1, 1, 0);
    step("R2", 0, MRS, 1, 2, 0);
    step("R5", 0, ACT, 1, 0, 0);
    step("R8", 0, PRE, 1, 1, 0);
    step("R4", 0, NOP, 0, 1, 0);
    step("R7", 0, RD, 1, 1, 1);
    step("R9", 0, WR, 1, 1, 0);
    step("R9", 0, PRE, 1, 1, 0);
    step("R8", 0, PRE, 1, 1, 0);
    step("R8", 0, NOP, 1, 0, 0);
    step("R8", 0, PRE, 1, 0, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 15);
      logic [2:0] c;
      case (r)
        0: c = MRS; 1: c = REF;
        2, 3: c = PRE; 4, 5, 6: c = ACT;
        7, 8, 9: c = RD; 10, 11: c = WR;
        default: c = NOP;
      endcase
      step("R11", ($urandom_range(0, 9) == 0), c, ($urandom_range(0, 5) != 0),
           $urandom_range(0, 3), 1'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule